// File: doc/BRIEF.md
# Post-Load Start-up Phase Sequencer

After a device has finished taking in its configuration, a short and fixed sequence hands control to the loaded design. This block runs that sequence. A start pulse begins an eight-phase walk, phases 0 through 7, at one phase per clock. Four one-shot events take effect along the way. The first releases the open-drain DONE line. The second lifts the global output tristate hold. The third lifts the global set/reset hold. The fourth turns on global write enable. The design is fully live once phase 7 has passed, and a completion flag then goes high.

Each event has its own 3-bit phase select. An in-range select places the event on any single phase from 1 to 6. Any other value falls back to a fixed default for that event. The optional synchronised mode supports chains of devices that must come up together. In that mode the three global events are held until the sensed DONE line, which all devices share in wired-AND fashion, is seen high through a two-flop synchroniser. The phase walk stalls in front of the first held event and resumes one clock after the line is seen high.

Every event is sticky. Only a reset returns the sequencer to its idle state.

Top module: `startup_seq`

## Requirements
- R1: After reset and before any start pulse: done_low_en_o=1, done_release_o=0, gts_hold_o=1, gsr_hold_o=1, gwe_en_o=0, seq_complete_o=0, with no change while no start pulse arrives.
- R2: A start_i pulse sampled in the idle state puts the walk in phase 0 after that edge. The walk then moves up one phase per clock to phase 7. seq_complete_o rises on the edge after phase 7, which is the 8th edge after the start edge, and stays high.
- R3: With each select holding a value from 1 to 6 (3-bit unsigned), an event's output changes on the edge that enters that phase, which is the Nth edge after the start edge for select N.
- R4: A select of 0 or 7 uses the default phase: 4 for DONE, 5 for the tristate release, and 6 for both the set/reset release and the write enable.
- R5: Once an event has taken effect, its output keeps the new level until rst_n is asserted, including after completion.
- R6: The DONE line is driven as a complementary pair. done_low_en_o=1 pulls the line low, and done_release_o=1 lets it float high. Exactly one of the two is high at all times.
- R7: With sync_mode_i=1, the effective phase of each global event becomes the larger of its own resolved phase and one plus the resolved DONE phase.
- R8: With sync_mode_i=1, the walk stalls before entering a global event's phase while the synchronised done_pin_i is low. A rise of done_pin_i takes effect on the third rising clock edge after it: two synchroniser flops, then one clock.
- R9: With sync_mode_i=0, done_pin_i has no effect, and the events follow R3 and R4 whether the pin is high or low.
- R10: A start_i pulse while the walk is running or already complete is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Start-up clock |
| rst_n | input | 1 | Active-low reset, asserted for each new configuration cycle |
| start_i | input | 1 | One-clock pulse that starts the walk |
| sync_mode_i | input | 1 | 1 = hold the global events for the sensed DONE line |
| sel_done_i | input | 3 | Phase select for the DONE release |
| sel_gts_i | input | 3 | Phase select for the tristate release |
| sel_gsr_i | input | 3 | Phase select for the set/reset release |
| sel_gwe_i | input | 3 | Phase select for the write enable |
| done_pin_i | input | 1 | Sensed level of the shared DONE line (asynchronous) |
| done_low_en_o | output | 1 | 1 = pull the DONE line low |
| done_release_o | output | 1 | 1 = let the DONE line float high |
| gts_hold_o | output | 1 | 1 = global outputs held in tristate |
| gsr_hold_o | output | 1 | 1 = global set/reset held |
| gwe_en_o | output | 1 | 1 = global writes enabled |
| seq_complete_o | output | 1 | Sequence has passed phase 7 |

## Verification
The bench walks the phase schedule for legal selects, both out-of-range codes and a shuffled ordering. A design that counted from the wrong edge would place every event one cycle early or late. A design that ignored the defaults would fire on phase 0 or phase 7, or never fire at all. In synchronised mode the bench holds the DONE line low from outside and checks that the walk freezes, then times the release to the exact edge. A design with one synchroniser flop too many or too few would miss that edge by one. A design that did not stall would run straight to completion. A second synchronised case places DONE after the global events to check that they are pushed behind it rather than deadlocking. Start pulses sent mid-walk and after completion are checked to leave the schedule alone, and a design that restarted on them would show events dropping back.

// File: rtl/startup_pkg.sv
package startup_pkg;

  localparam int PHASE_W = 3;
  localparam int NUM_EVT = 4;

  typedef logic [PHASE_W-1:0] phase_t;

  localparam phase_t FIRST_PHASE = '0;
  localparam phase_t LAST_PHASE  = '1;
  localparam phase_t SEL_MIN     = phase_t'(1);
  localparam phase_t SEL_MAX     = LAST_PHASE - phase_t'(1);

  typedef enum logic [1:0] {
    EV_DONE = 2'd0,
    EV_GTS  = 2'd1,
    EV_GSR  = 2'd2,
    EV_GWE  = 2'd3
  } evt_e;

  // Fallback phase for an event whose select is out of range.
  function automatic phase_t default_phase(evt_e ev);
    case (ev)
      EV_DONE: return phase_t'(4);
      EV_GTS:  return phase_t'(5);
      default: return phase_t'(6);
    endcase
  endfunction

  function automatic logic sel_legal(phase_t sel);
    return (sel >= SEL_MIN) && (sel <= SEL_MAX);
  endfunction

  function automatic phase_t resolve_phase(phase_t sel, evt_e ev);
    return sel_legal(sel) ? sel : default_phase(ev);
  endfunction

  // In synchronised mode a global event may not precede the DONE release.
  function automatic phase_t gate_after_done(phase_t own, phase_t done_ph);
    return (own > done_ph) ? own : done_ph + phase_t'(1);
  endfunction

  function automatic phase_t next_phase(phase_t p);
    return p + phase_t'(1);
  endfunction

endpackage

// File: rtl/su_pin_sync.sv
module su_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= pin_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  assign level_o = chain_q[LAST];

endmodule

// File: rtl/su_phase_ctr.sv
module su_phase_ctr
  import startup_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  logic   stall_i,
  output logic   run_o,
  output logic   complete_o,
  output phase_t phase_o,
  output phase_t phase_nxt_o,
  output logic   enter_o
);
  logic   run_q, complete_q;
  phase_t phase_q;

  logic idle, start_ok, advance, finish;

  always_comb begin
    idle     = !run_q && !complete_q;
    start_ok = start_i && idle;
    advance  = run_q && !stall_i && (phase_q != LAST_PHASE);
    finish   = run_q && !stall_i && (phase_q == LAST_PHASE);
    enter_o  = start_ok || advance;
    if (start_ok)     phase_nxt_o = FIRST_PHASE;
    else if (advance) phase_nxt_o = next_phase(phase_q);
    else              phase_nxt_o = phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      complete_q <= 1'b0;
      phase_q    <= FIRST_PHASE;
    end else begin
      phase_q <= phase_nxt_o;
      if (start_ok) run_q <= 1'b1;
      else if (finish) begin
        run_q      <= 1'b0;
        complete_q <= 1'b1;
      end
    end
  end

  assign run_o      = run_q;
  assign complete_o = complete_q;
  assign phase_o    = phase_q;

  // The walk freezes while any held event is waiting (R8).
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && stall_i) |=> $stable(phase_q));

  // Completion only follows the last phase (R2).
  assert_complete_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(complete_q) |-> ($past(phase_q) == LAST_PHASE));

endmodule

// File: rtl/su_event_slot.sv
module su_event_slot
  import startup_pkg::*;
#(
  parameter evt_e EVT = EV_DONE
) (
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t sel_i,
  input  logic   sync_en_i,
  input  phase_t done_eff_i,
  input  logic   ext_high_i,
  input  logic   run_i,
  input  phase_t phase_i,
  input  logic   enter_i,
  input  phase_t phase_nxt_i,
  output logic   fired_o,
  output phase_t eff_o,
  output logic   wait_o
);
  localparam bit GATED = (EVT != EV_DONE);

  phase_t base_ph;
  logic   held, fire, fired_q;

  always_comb begin
    base_ph = resolve_phase(sel_i, EVT);
    eff_o   = (GATED && sync_en_i) ? gate_after_done(base_ph, done_eff_i) : base_ph;
    held    = GATED && sync_en_i && !ext_high_i;
    wait_o  = held && run_i && !fired_q && (next_phase(phase_i) == eff_o);
    fire    = enter_i && (phase_nxt_i == eff_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fired_q <= 1'b0;
    else        fired_q <= fired_q | fire;
  end

  assign fired_o = fired_q;

  // An event takes effect exactly as the walk enters its phase (R3).
  assert_fire_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fired_q) |-> (phase_i == eff_o));

  generate
    if (GATED) begin : g_gated
      // A held event fires only after the synchronised line was high (R8).
      assert_sync_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fired_q) && sync_en_i) |-> $past(ext_high_i));
    end
  endgenerate

endmodule

// File: rtl/startup_seq.sv
module startup_seq
  import startup_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                sync_mode_i,
  input  logic [PHASE_W-1:0]  sel_done_i,
  input  logic [PHASE_W-1:0]  sel_gts_i,
  input  logic [PHASE_W-1:0]  sel_gsr_i,
  input  logic [PHASE_W-1:0]  sel_gwe_i,
  input  logic                done_pin_i,
  output logic                done_low_en_o,
  output logic                done_release_o,
  output logic                gts_hold_o,
  output logic                gsr_hold_o,
  output logic                gwe_en_o,
  output logic                seq_complete_o
);
  phase_t sel_arr [NUM_EVT];
  logic   fired   [NUM_EVT];
  phase_t eff_arr [NUM_EVT];
  logic   wait_v  [NUM_EVT];

  logic   ext_high, run, enter, stall;
  phase_t phase, phase_nxt, done_eff;

  always_comb begin
    sel_arr[EV_DONE] = sel_done_i;
    sel_arr[EV_GTS]  = sel_gts_i;
    sel_arr[EV_GSR]  = sel_gsr_i;
    sel_arr[EV_GWE]  = sel_gwe_i;
    done_eff         = resolve_phase(sel_done_i, EV_DONE);
    stall            = 1'b0;
    for (int e = 0; e < NUM_EVT; e++) stall = stall | wait_v[e];
  end

  su_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (done_pin_i),
    .level_o (ext_high)
  );

  su_phase_ctr u_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stall_i     (stall),
    .run_o       (run),
    .complete_o  (seq_complete_o),
    .phase_o     (phase),
    .phase_nxt_o (phase_nxt),
    .enter_o     (enter)
  );

  generate
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
      su_event_slot #(.EVT(evt_e'(i))) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (sel_arr[i]),
        .sync_en_i   (sync_mode_i),
        .done_eff_i  (done_eff),
        .ext_high_i  (ext_high),
        .run_i       (run),
        .phase_i     (phase),
        .enter_i     (enter),
        .phase_nxt_i (phase_nxt),
        .fired_o     (fired[i]),
        .eff_o       (eff_arr[i]),
        .wait_o      (wait_v[i])
      );
    end
  endgenerate

  assign done_release_o = fired[EV_DONE];
  assign done_low_en_o  = !fired[EV_DONE];
  assign gts_hold_o     = !fired[EV_GTS];
  assign gsr_hold_o     = !fired[EV_GSR];
  assign gwe_en_o       = fired[EV_GWE];

  // Completion implies every event has taken effect (R2).
  assert_complete_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_complete_o) |-> (done_release_o && !gts_hold_o && !gsr_hold_o && gwe_en_o));

  // The released DONE line stays released (R5).
  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_release_o) |=> done_release_o);

  // A held global event never sits behind or with the DONE release (R7).
  assert_gate_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode_i |-> ((eff_arr[EV_GTS] > done_eff) && (eff_arr[EV_GSR] > done_eff)
                     && (eff_arr[EV_GWE] > done_eff)));

endmodule

// File: tb/tb_startup_seq.sv
module tb_startup_seq;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, start, sync_mode, allow;
  logic [2:0] s_done, s_gts, s_gsr, s_gwe;
  logic       done_low_en, done_release, gts_hold, gsr_hold, gwe_en, complete;
  logic       done_pin;

  // Shared wired-AND line: high only when this device and the outside agree.
  assign done_pin = done_release & allow;

  startup_seq dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start),
    .sync_mode_i    (sync_mode),
    .sel_done_i     (s_done),
    .sel_gts_i      (s_gts),
    .sel_gsr_i      (s_gsr),
    .sel_gwe_i      (s_gwe),
    .done_pin_i     (done_pin),
    .done_low_en_o  (done_low_en),
    .done_release_o (done_release),
    .gts_hold_o     (gts_hold),
    .gsr_hold_o     (gsr_hold),
    .gwe_en_o       (gwe_en),
    .seq_complete_o (complete)
  );

  typedef struct packed {
    logic [2:0] sd, sg, sr, sw;
    logic [2:0] pd, pg, pr, pw;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 3'd2, 3'd3, 3'd4, 3'd1, 3'd2, 3'd3, 3'd4},
    '{3'd6, 3'd6, 3'd6, 3'd6, 3'd6, 3'd6, 3'd6, 3'd6},
    '{3'd0, 3'd0, 3'd0, 3'd0, 3'd4, 3'd5, 3'd6, 3'd6},
    '{3'd7, 3'd7, 3'd7, 3'd7, 3'd4, 3'd5, 3'd6, 3'd6},
    '{3'd3, 3'd1, 3'd6, 3'd2, 3'd3, 3'd1, 3'd6, 3'd2},
    '{3'd5, 3'd4, 3'd0, 3'd1, 3'd5, 3'd4, 3'd6, 3'd1}
  };

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic check_outs(input bit fd, input bit fg, input bit fr, input bit fw,
                            input bit fc, input string tag);
    chk(done_release, fd,  {tag, " done_release"});
    chk(done_low_en,  !fd, {tag, " done_low_en R6"});
    chk(gts_hold,     !fg, {tag, " gts_hold"});
    chk(gsr_hold,     !fr, {tag, " gsr_hold"});
    chk(gwe_en,       fw,  {tag, " gwe_en"});
    chk(complete,     fc,  {tag, " complete"});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic config_set(input logic [2:0] d, input logic [2:0] g, input logic [2:0] r,
                            input logic [2:0] w, input logic sm, input logic al);
    s_done = d; s_gts = g; s_gsr = r; s_gwe = w; sync_mode = sm; allow = al;
  endtask

  // Leaves the bench at the negedge of phase-0 cycle.
  task automatic start_pulse();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    config_set(3'd1, 3'd2, 3'd3, 3'd4, 1'b0, 1'b0);

    // R1: idle after reset, no change without a start pulse.
    do_reset();
    for (int k = 0; k < 5; k++) begin
      check_outs(0, 0, 0, 0, 0, $sformatf("R1 idle c%0d", k));
      @(negedge clk);
    end

    // Table walk: R2, R3, R4, R6 and R9 (pin level alternates, sync off).
    for (int i = 0; i < NV; i++) begin
      config_set(VECS[i].sd, VECS[i].sg, VECS[i].sr, VECS[i].sw, 1'b0, logic'(i % 2));
      do_reset();
      check_outs(0, 0, 0, 0, 0, $sformatf("R1 vec%0d pre", i));
      start_pulse();
      for (int k = 0; k <= 10; k++) begin
        if (k > 0) @(negedge clk);
        check_outs(k >= int'(VECS[i].pd), k >= int'(VECS[i].pg),
                   k >= int'(VECS[i].pr), k >= int'(VECS[i].pw), k >= 8,
                   $sformatf("R2/R3/R4/R9 vec%0d c%0d", i, k));
      end
    end

    // R10: start pulse mid-walk and after completion; R5: outputs hold.
    config_set(3'd1, 3'd2, 3'd3, 3'd4, 1'b0, 1'b1);
    do_reset();
    start_pulse();
    for (int k = 0; k <= 10; k++) begin
      if (k > 0) @(negedge clk);
      check_outs(k >= 1, k >= 2, k >= 3, k >= 4, k >= 8, $sformatf("R10 mid c%0d", k));
      start = (k == 2);
    end
    start = 1'b0;
    start_pulse();
    for (int k = 0; k < 10; k++) begin
      check_outs(1, 1, 1, 1, 1, $sformatf("R10/R5 after c%0d", k));
      @(negedge clk);
    end

    // R8: outside agent holds DONE low, walk stalls before phase 3.
    config_set(3'd2, 3'd3, 3'd3, 3'd5, 1'b1, 1'b0);
    do_reset();
    start_pulse();
    for (int k = 0; k <= 2; k++) begin
      if (k > 0) @(negedge clk);
      check_outs(k >= 2, 0, 0, 0, 0, $sformatf("R8 pre c%0d", k));
    end
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check_outs(1, 0, 0, 0, 0, $sformatf("R8 stalled c%0d", k));
    end
    allow = 1'b1;
    @(negedge clk); check_outs(1, 0, 0, 0, 0, "R8 sync edge1");
    @(negedge clk); check_outs(1, 0, 0, 0, 0, "R8 sync edge2");
    @(negedge clk); check_outs(1, 1, 1, 0, 0, "R8 fire edge3");
    @(negedge clk); check_outs(1, 1, 1, 0, 0, "R8 phase4");
    @(negedge clk); check_outs(1, 1, 1, 1, 0, "R8 phase5");
    @(negedge clk); check_outs(1, 1, 1, 1, 0, "R8 phase6");
    @(negedge clk); check_outs(1, 1, 1, 1, 0, "R8 phase7");
    @(negedge clk); check_outs(1, 1, 1, 1, 1, "R8 complete");

    // R7: DONE placed late, global events pushed to phase 6, loopback delay.
    config_set(3'd5, 3'd2, 3'd0, 3'd7, 1'b1, 1'b1);
    do_reset();
    start_pulse();
    for (int k = 0; k <= 11; k++) begin
      if (k > 0) @(negedge clk);
      check_outs(k >= 5, k >= 8, k >= 8, k >= 8, k >= 10, $sformatf("R7/R8 late c%0d", k));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule